// File: doc/BRIEF.md
# Dual-Edge Column Data Loader

This block collects gray-level values for a row of display columns from an 8-bit parallel bus. While the chip-select input is active, it takes one byte on every transition of the shift clock, both rising and falling. So one full shift-clock period delivers two column values. The bytes fill the column registers in order, starting with channel 1.

Once every channel holds a value, the block stops writing and raises a frame-full flag. It also drives a chip-select output, so that a second loader wired in cascade takes the bytes that follow.

The shift clock, the chip select and the data bus are all asynchronous to the block. A fast system clock samples them through synchronizers, and the shift-clock transitions are found by comparing successive synchronized samples. All stored bytes are presented in parallel on one wide output bus for the pulse-width stage that follows.

Top module: `dcl_top`

## Requirements
- R1: After the asynchronous reset `rst_ni`, every channel byte, `full_o` and `csel_o` read 0.
- R2: While `csel_i` is high, a rising transition of `sclk_i` stores the byte on `data_i`. `data_i[7]` is the most significant bit and is stored unchanged.
- R3: While `csel_i` is high, a falling transition of `sclk_i` also stores a byte.
- R4: The k-th byte accepted since `csel_i` rose goes to channel k, for k from 1 to NUM_CH. Channel k appears on `chan_data_o[8k-1:8k-8]`, so channel 1 is on bits 7:0.
- R5: While `csel_i` is low, `sclk_i` transitions change no channel byte.
- R6: When all NUM_CH channels are written, `full_o` goes high and `csel_o` follows `csel_i`. With 32 channels this takes 16 full shift-clock periods. `csel_o` is never high while `full_o` is low.
- R7: While `full_o` is high, further `sclk_i` transitions change no channel byte.
- R8: Deasserting `csel_i` clears `full_o` and `csel_o`. The next frame starts again at channel 1, and the other channels keep their bytes until they are overwritten.
- R9: A stored byte becomes visible on `chan_data_o` at the third rising `clk_i` edge after the `sclk_i` transition, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Shift clock, both edges active |
| csel_i | input | 1 | Chip-select input, active high |
| data_i | input | 8 | Parallel gray-level byte, bit 7 MSB |
| chan_data_o | output | NUM_CH*8 | Stored bytes, channel 1 in the low byte |
| full_o | output | 1 | All channels written in this frame |
| csel_o | output | 1 | Chip select to the cascaded next loader |

## Verification
Every input passes two synchronizer flops, and a stored byte is written one edge after that. A byte is therefore due on the third rising edge after a shift-clock toggle, and the R9 check samples on the falling edge just before that point and again just after it.

`full_o` and `csel_o` follow the last write by the same three edges. After `csel_i` drops, the synchronized chip select needs two edges to take effect. The bench waits five system cycles after each toggle and four after each chip-select change before it samples, always on the falling edge of `clk_i`. The data bus is held stable from three cycles before each toggle until five cycles after it.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } sclk_edge_t;
endpackage

// File: rtl/dcl_sync.sv
module dcl_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[s] <= '0;
      else if (s == 0) st_q[s] <= d_i;
      else st_q[s] <= st_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/dcl_edge.sv
module dcl_edge
  import dcl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_s_i,
  output sclk_edge_t edge_o
);
  logic sclk_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d_q <= 1'b0;
    else sclk_d_q <= sclk_s_i;
  end

  assign edge_o.rise = sclk_s_i & ~sclk_d_q;
  assign edge_o.fall = ~sclk_s_i & sclk_d_q;
endmodule

// File: rtl/dcl_store.sv
module dcl_store
  import dcl_pkg::*;
#(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = $clog2(NUM_CH + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  sclk_edge_t               edge_i,
  input  logic                     cs_i,
  input  logic [DATA_W-1:0]        data_i,
  output logic [NUM_CH*DATA_W-1:0] chan_o,
  output logic [NUM_CH-1:0]        we_o,
  output logic                     wr_en_o,
  output logic [PTR_W-1:0]         ptr_o,
  output logic                     full_o
);
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_CH);

  logic [PTR_W-1:0] ptr_q;
  logic             full;
  logic             wr_en;

  assign full  = (ptr_q == PTR_END);
  assign wr_en = (edge_i.rise | edge_i.fall) & cs_i & ~full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (!cs_i) ptr_q <= '0;
    else if (wr_en) ptr_q <= ptr_q + 1'b1;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [DATA_W-1:0] byte_q;
    assign we_o[c] = wr_en & (ptr_q == PTR_W'(c));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_q <= '0;
      else if (we_o[c]) byte_q <= data_i;
    end
    assign chan_o[c*DATA_W +: DATA_W] = byte_q;
  end

  assign wr_en_o = wr_en;
  assign ptr_o   = ptr_q;
  assign full_o  = full;
endmodule

// File: rtl/dcl_top.sv
module dcl_top
  import dcl_pkg::*;
#(
  parameter int unsigned NUM_CH      = 32,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PTR_W = $clog2(NUM_CH + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sclk_i,
  input  logic                     csel_i,
  input  logic [DATA_W-1:0]        data_i,
  output logic [NUM_CH*DATA_W-1:0] chan_data_o,
  output logic                     full_o,
  output logic                     csel_o
);
  logic              sclk_s, cs_s;
  logic [DATA_W-1:0] data_s;
  sclk_edge_t        sclk_edge;
  logic [NUM_CH-1:0] we;
  logic              wr_en;
  logic [PTR_W-1:0]  ptr;
  logic              full;

  dcl_sync #(.W(2), .STAGES(SYNC_STAGES)) u_ctl_sync (
    .clk_i, .rst_ni, .d_i({sclk_i, csel_i}), .q_o({sclk_s, cs_s})
  );

  dcl_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_dat_sync (
    .clk_i, .rst_ni, .d_i(data_i), .q_o(data_s)
  );

  dcl_edge u_edge (
    .clk_i, .rst_ni, .sclk_s_i(sclk_s), .edge_o(sclk_edge)
  );

  dcl_store #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .edge_i (sclk_edge),
    .cs_i   (cs_s),
    .data_i (data_s),
    .chan_o (chan_data_o),
    .we_o   (we),
    .wr_en_o(wr_en),
    .ptr_o  (ptr),
    .full_o (full)
  );

  assign full_o = full;
  assign csel_o = full & cs_s;
endmodule

// File: rtl/dcl_chk.sv
module dcl_chk #(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = $clog2(NUM_CH + 1)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     cs_s,
  input logic                     wr_en,
  input logic [PTR_W-1:0]         ptr,
  input logic [NUM_CH-1:0]        we,
  input logic [NUM_CH*DATA_W-1:0] chan_data_o,
  input logic                     full_o,
  input logic                     csel_o
);
  // R4
  one_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we));
  // R4
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> (ptr == $past(ptr) + 1'b1));
  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s |=> $stable(chan_data_o));
  // R6
  cso_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csel_o |-> full_o);
  // R7
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> $stable(chan_data_o));
  // R8
  cs_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s |=> (!full_o && ptr == '0));
endmodule

bind dcl_top dcl_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .cs_s(cs_s), .wr_en(wr_en), .ptr(ptr), .we(we),
  .chan_data_o, .full_o, .csel_o
);

// File: tb/dcl_top_tb.sv
module dcl_top_tb_top;
  localparam int NCH = 32;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           sclk_i = 1'b0;
  logic           csel_i = 1'b0;
  logic [7:0]     data_i = '0;
  logic [NCH*8-1:0] chan_data_o;
  logic           full_o, csel_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] exp_q [NCH];

  always #10 clk = ~clk;

  dcl_top dut_i (
    .clk_i(clk), .rst_ni, .sclk_i, .csel_i, .data_i,
    .chan_data_o, .full_o, .csel_o
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    for (int c = 0; c < NCH; c++)
      chk(req, $sformatf("chan %0d", c + 1), chan_data_o[c*8 +: 8], exp_q[c]);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Present a byte, toggle the shift clock, let the result settle
  task automatic shift_byte(input logic [7:0] b);
    @(negedge clk);
    data_i = b;
    cycles(3);
    sclk_i = ~sclk_i;
    cycles(5);
  endtask

  task automatic t_reset;
    for (int c = 0; c < NCH; c++) exp_q[c] = '0;
    chk_all("R1");
    chk("R1", "full_o", full_o, 0);
    chk("R1", "csel_o", csel_o, 0);
  endtask

  task automatic t_frame;
    @(negedge clk);
    csel_i = 1'b1;
    cycles(4);
    for (int k = 0; k < NCH; k++) begin
      logic [7:0] b = 8'(k * 37 + 9) ^ 8'h80;
      shift_byte(b);
      exp_q[k] = b;
      if (k == 0) chk("R2", "rise byte ch1", chan_data_o[7:0], b);
      if (k == 1) chk("R3", "fall byte ch2", chan_data_o[15:8], b);
      if (k == NCH - 2) chk("R6", "full_o early", full_o, 0);
    end
    chk_all("R4");
    chk("R6", "full_o", full_o, 1);
    chk("R6", "csel_o", csel_o, 1);
    chk("R6", "sclk level after 16 periods", sclk_i, 0);
  endtask

  task automatic t_overflow;
    shift_byte(8'h5A);
    shift_byte(8'hC3);
    chk_all("R7");
    chk("R7", "csel_o held", csel_o, 1);
  endtask

  task automatic t_idle;
    @(negedge clk);
    csel_i = 1'b0;
    cycles(4);
    chk("R8", "csel_o drop", csel_o, 0);
    chk("R8", "full_o drop", full_o, 0);
    shift_byte(8'h11);
    shift_byte(8'h22);
    chk_all("R5");
  endtask

  task automatic t_restart;
    @(negedge clk);
    csel_i = 1'b1;
    cycles(4);
    @(negedge clk);
    data_i = 8'hE7;
    cycles(3);
    sclk_i = ~sclk_i;
    cycles(2);
    chk("R9", "too early", chan_data_o[7:0], exp_q[0]);
    cycles(1);
    chk("R9", "on time", chan_data_o[7:0], 8'hE7);
    exp_q[0] = 8'hE7;
    cycles(3);
    chk_all("R8");
    chk("R8", "full_o after restart", full_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cycles(3);
    t_reset();
    rst_ni = 1'b1;
    cycles(2);
    t_frame();
    t_overflow();
    t_idle();
    t_restart();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule